// File: doc/BRIEF.md
# Shared-Bus Operand Phase Sequencer

This block controls the execution of one register-register instruction over a single shared 32-bit data bus. Three parallel buses would carry two operands and a result at the same time. Here the block gives each transfer its own phase instead. When a start strobe arrives, the block first selects the first source register and signals the functional unit to latch it into its A input. It then selects the second source register and has the functional unit latch it into its B input. Last, it lets the functional unit drive its result onto the bus and writes that result to the destination register.

The first operand phase carries no register-file write. The block uses that idle write slot to advance the program counter by one instruction step. All control outputs come from registers. The shared bus is modelled as a one-hot selected multiplexer, so two sources can never drive it at once. A write-back aimed at register 0 is blocked, which keeps that register at zero.

Top module: `opseq_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `rf_rd_en`, `rf_wr_en`, `bus_drv`, `lat_a_en`, `lat_b_en`, `pc_upd` and `rf_addr` are all zero, `bus_data` is zero and `pc` equals `PC_RESET` (default 0). This holds even when reset arrives in the middle of an instruction.
- R2: A `start` sampled at a clock edge while idle starts the first operand phase in the next cycle. In that phase `rf_addr` equals `rs1_idx`, `rf_rd_en`=1, `rf_wr_en`=0, `bus_drv`=2'b01 (bit 0 is the register file), `lat_a_en`=1, `lat_b_en`=0 and `busy`=1.
- R3: The cycle after the first operand phase is the second operand phase. In it `rf_addr` equals the captured `rs2_idx`, `rf_rd_en`=1, `bus_drv`=2'b01, `lat_b_en`=1 and `lat_a_en`=0.
- R4: The cycle after the second operand phase is write-back. In it `rf_addr` equals the captured `rd_idx`, `rf_rd_en`=0, `bus_drv`=2'b10 (bit 1 is the functional unit), both latch enables are 0 and `rf_wr_en`=1 when `rd_idx` is nonzero.
- R5: A write-back whose destination index is 0 keeps `rf_wr_en` at 0 for the whole instruction.
- R6: `pc_upd` is high only in the first operand phase. `pc` rises by `PC_STEP` (default 4) at the end of that phase, so it is already updated in the second operand phase, and it does not change at any other time.
- R7: `done` is high for exactly the one cycle after write-back, and `busy` is low in that cycle. `busy` is high in each of the three phases.
- R8: A `start` while `busy` is high is ignored. Changes to `rs1_idx`, `rs2_idx` or `rd_idx` after the accepted start have no effect on the addresses of that instruction.
- R9: `bus_data` equals `rf_rdata` when `bus_drv`=2'b01, equals `fu_result` when `bus_drv`=2'b10, and is zero when `bus_drv` is zero.
- R10: At most one bit of `bus_drv` is set at any time, and `rf_rd_en` and `rf_wr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for one instruction |
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| rd_idx | input | 5 | Destination register index |
| rf_rdata | input | 32 | Register-file read data (bus source 0) |
| fu_result | input | 32 | Functional-unit result (bus source 1) |
| rf_addr | output | 5 | Register-file address for the current phase |
| rf_rd_en | output | 1 | Register-file read enable |
| rf_wr_en | output | 1 | Register-file write enable, data taken from `bus_data` |
| bus_drv | output | 2 | One-hot bus drive enables: bit 0 register file, bit 1 functional unit |
| bus_data | output | 32 | Value on the shared bus |
| lat_a_en | output | 1 | Functional-unit A operand latch enable |
| lat_b_en | output | 1 | Functional-unit B operand latch enable |
| pc | output | 32 | Program counter |
| pc_upd | output | 1 | Program counter update slot active |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse after write-back |

## Verification
The start is sampled at edge k. Because every control output is registered, the first operand phase shows at the ports right after edge k. The second operand phase shows after edge k+1, write-back after edge k+2 and the `done` pulse after edge k+3. The incremented `pc` is due after edge k+1, one register past `pc_upd`. `bus_data` is combinational from the registered drive enables, so it follows new source data in the same cycle. The bench changes inputs on the falling edge and checks every output shortly afterwards, in the cycle given above, against a timeline computed from the requirements. During the busy cycles it also holds `start` high and scrambles the indices, to show that neither has any effect.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  // Phase order is behaviour: operand A, operand B, then write-back.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPA  = 2'd1,
    PH_OPB  = 2'd2,
    PH_WB   = 2'd3
  } phase_e;

  // Bus source slots; the one-hot drive vector uses these bit positions.
  localparam int SRC_RF = 0;
  localparam int SRC_FU = 1;
  localparam int NSRC   = 2;

endpackage

// File: rtl/opseq_phase.sv
module opseq_phase
  import opseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e phase_q,
  output phase_e phase_nxt,
  output logic   accept
);

  assign accept = start && (phase_q == PH_IDLE);

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_IDLE: if (accept) phase_nxt = PH_OPA;
      PH_OPA:  phase_nxt = PH_OPB;
      PH_OPB:  phase_nxt = PH_WB;
      PH_WB:   phase_nxt = PH_IDLE;
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_nxt;
  end

endmodule

// File: rtl/opseq_ctl.sv
module opseq_ctl
  import opseq_pkg::*;
#(
  parameter int AW = 5
)(
  input  logic            clk,
  input  logic            rst,
  input  phase_e          phase_q,
  input  phase_e          phase_nxt,
  input  logic            accept,
  input  logic [AW-1:0]   rs1_idx,
  input  logic [AW-1:0]   rs2_idx,
  input  logic [AW-1:0]   rd_idx,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_rd_en,
  output logic            rf_wr_en,
  output logic [NSRC-1:0] bus_drv,
  output logic            lat_a_en,
  output logic            lat_b_en,
  output logic            pc_upd,
  output logic            done
);

  logic [AW-1:0] rs2_q;
  logic [AW-1:0] rd_q;

  // Indices captured once per instruction; later input changes are ignored.
  always_ff @(posedge clk) begin
    if (rst) begin
      rs2_q <= '0;
      rd_q  <= '0;
    end else if (accept) begin
      rs2_q <= rs2_idx;
      rd_q  <= rd_idx;
    end
  end

  // Outputs registered from the next phase so each lines up with its phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_addr  <= '0;
      rf_rd_en <= 1'b0;
      rf_wr_en <= 1'b0;
      bus_drv  <= '0;
      lat_a_en <= 1'b0;
      lat_b_en <= 1'b0;
      pc_upd   <= 1'b0;
      done     <= 1'b0;
    end else begin
      rf_addr  <= '0;
      rf_rd_en <= 1'b0;
      rf_wr_en <= 1'b0;
      bus_drv  <= '0;
      lat_a_en <= 1'b0;
      lat_b_en <= 1'b0;
      pc_upd   <= 1'b0;
      done     <= (phase_q == PH_WB);
      unique case (phase_nxt)
        PH_OPA: begin
          rf_addr         <= rs1_idx;
          rf_rd_en        <= 1'b1;
          bus_drv[SRC_RF] <= 1'b1;
          lat_a_en        <= 1'b1;
          pc_upd          <= 1'b1;   // write slot is free in this phase
        end
        PH_OPB: begin
          rf_addr         <= rs2_q;
          rf_rd_en        <= 1'b1;
          bus_drv[SRC_RF] <= 1'b1;
          lat_b_en        <= 1'b1;
        end
        PH_WB: begin
          rf_addr         <= rd_q;
          rf_wr_en        <= (rd_q != '0);
          bus_drv[SRC_FU] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/opseq_pc.sv
module opseq_pc #(
  parameter int          DW       = 32,
  parameter int          STEP     = 4,
  parameter logic [DW-1:0] RESET_PC = '0
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  output logic [DW-1:0] pc
);

  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_ff @(posedge clk) begin
    if (rst)      pc <= RESET_PC;
    else if (upd) pc <= pc + STEP_V;
  end

endmodule

// File: rtl/opseq_bus.sv
module opseq_bus #(
  parameter int DW   = 32,
  parameter int NSRC = 2
)(
  input  logic [NSRC-1:0]    sel,
  input  logic [NSRC*DW-1:0] src,
  output logic [DW-1:0]      bus
);

  logic [DW-1:0] term [NSRC];

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    assign term[gi] = sel[gi] ? src[gi*DW +: DW] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | term[i];
  end

endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 5,
  parameter int            PC_STEP  = 4,
  parameter logic [DW-1:0] PC_RESET = '0
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   rs1_idx,
  input  logic [AW-1:0]   rs2_idx,
  input  logic [AW-1:0]   rd_idx,
  input  logic [DW-1:0]   rf_rdata,
  input  logic [DW-1:0]   fu_result,
  output logic [AW-1:0]   rf_addr,
  output logic            rf_rd_en,
  output logic            rf_wr_en,
  output logic [NSRC-1:0] bus_drv,
  output logic [DW-1:0]   bus_data,
  output logic            lat_a_en,
  output logic            lat_b_en,
  output logic [DW-1:0]   pc,
  output logic            pc_upd,
  output logic            busy,
  output logic            done
);

  phase_e phase_q;
  phase_e phase_nxt;
  logic   accept;
  logic [NSRC*DW-1:0] bus_src;

  opseq_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .accept    (accept)
  );

  opseq_ctl #(.AW(AW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .accept    (accept),
    .rs1_idx   (rs1_idx),
    .rs2_idx   (rs2_idx),
    .rd_idx    (rd_idx),
    .rf_addr   (rf_addr),
    .rf_rd_en  (rf_rd_en),
    .rf_wr_en  (rf_wr_en),
    .bus_drv   (bus_drv),
    .lat_a_en  (lat_a_en),
    .lat_b_en  (lat_b_en),
    .pc_upd    (pc_upd),
    .done      (done)
  );

  opseq_pc #(.DW(DW), .STEP(PC_STEP), .RESET_PC(PC_RESET)) u_pc (
    .clk (clk),
    .rst (rst),
    .upd (pc_upd),
    .pc  (pc)
  );

  assign bus_src[SRC_RF*DW +: DW] = rf_rdata;
  assign bus_src[SRC_FU*DW +: DW] = fu_result;

  opseq_bus #(.DW(DW), .NSRC(NSRC)) u_bus (
    .sel (bus_drv),
    .src (bus_src),
    .bus (bus_data)
  );

  assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int DW      = 32,
  parameter int AW      = 5,
  parameter int PC_STEP = 4
)(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [1:0]    bus_drv,
  input logic          rf_rd_en,
  input logic          rf_wr_en,
  input logic [AW-1:0] rf_addr,
  input logic          lat_a_en,
  input logic          lat_b_en,
  input logic          pc_upd,
  input logic [DW-1:0] pc
);

  localparam logic [DW-1:0] STEP_V = DW'(PC_STEP);

  a_r10_onehot_drive: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_drv));

  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(rf_rd_en && rf_wr_en));

  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (lat_a_en && pc_upd && bus_drv == 2'b01));

  a_r3_b_after_a: assert property (@(posedge clk) disable iff (rst)
    lat_a_en |=> (lat_b_en && rf_rd_en && !lat_a_en));

  a_r4_wb_after_b: assert property (@(posedge clk) disable iff (rst)
    lat_b_en |=> (bus_drv == 2'b10 && !rf_rd_en));

  a_r5_no_r0_write: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (rf_addr != '0));

  a_r6_pc_step: assert property (@(posedge clk) disable iff (rst)
    pc_upd |=> (pc == $past(pc) + STEP_V));

  a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_upd |=> $stable(pc));

  a_r7_done_after_wb: assert property (@(posedge clk) disable iff (rst)
    bus_drv[1] |=> (done && !busy));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind opseq_top opseq_chk #(.DW(DW), .AW(AW), .PC_STEP(PC_STEP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .bus_drv  (bus_drv),
  .rf_rd_en (rf_rd_en),
  .rf_wr_en (rf_wr_en),
  .rf_addr  (rf_addr),
  .lat_a_en (lat_a_en),
  .lat_b_en (lat_b_en),
  .pc_upd   (pc_upd),
  .pc       (pc)
);

// File: tb/tb_opseq_top.sv
`timescale 1ns/1ps
module tb_opseq_top;

  localparam int DW = 32;
  localparam int AW = 5;
  localparam logic [DW-1:0] STEP = 32'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] rs1_idx = '0, rs2_idx = '0, rd_idx = '0;
  logic [DW-1:0] rf_rdata = '0, fu_result = '0;
  logic [AW-1:0] rf_addr;
  logic          rf_rd_en, rf_wr_en, lat_a_en, lat_b_en, pc_upd, busy, done;
  logic [1:0]    bus_drv;
  logic [DW-1:0] bus_data, pc;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic [DW-1:0] pc_exp = '0;

  always #2.5 clk = ~clk;

  opseq_top dut (
    .clk(clk), .rst(rst), .start(start),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
    .rf_rdata(rf_rdata), .fu_result(fu_result),
    .rf_addr(rf_addr), .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en),
    .bus_drv(bus_drv), .bus_data(bus_data),
    .lat_a_en(lat_a_en), .lat_b_en(lat_b_en),
    .pc(pc), .pc_upd(pc_upd), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_bus(input logic [1:0] drv,
                                            input logic [DW-1:0] rfd,
                                            input logic [DW-1:0] fud);
    case (drv)
      2'b01:   return rfd;
      2'b10:   return fud;
      default: return '0;
    endcase
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic rand_data();
    rf_rdata  = $urandom;
    fu_result = $urandom;
  endtask

  task automatic check_idle_r1();
    chk("R1 busy",   {31'd0, busy},     32'd0);
    chk("R1 done",   {31'd0, done},     32'd0);
    chk("R1 drv",    {30'd0, bus_drv},  32'd0);
    chk("R1 rd_en",  {31'd0, rf_rd_en}, 32'd0);
    chk("R1 wr_en",  {31'd0, rf_wr_en}, 32'd0);
    chk("R1 lat",    {30'd0, lat_a_en, lat_b_en}, 32'd0);
    chk("R1 pc_upd", {31'd0, pc_upd},   32'd0);
    chk("R1 addr",   {27'd0, rf_addr},  32'd0);
    chk("R1 bus",    bus_data,          32'd0);
    chk("R1 pc",     pc,                32'd0);
  endtask

  // One instruction; noisy=1 holds start high and scrambles indices while busy (R8).
  task automatic run_instr(input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic [AW-1:0] d, input bit noisy);
    @(negedge clk);
    rand_data();
    #1;
    chk("R7 done low before start", {31'd0, done}, 32'd0);
    chk("R8 idle before start", {31'd0, busy}, 32'd0);
    chk("R9 bus idle", bus_data, 32'd0);
    start = 1'b1; rs1_idx = a; rs2_idx = b; rd_idx = d;
    // first operand phase
    @(negedge clk);
    start = noisy;
    if (noisy) begin rs1_idx = $urandom; rs2_idx = $urandom; rd_idx = $urandom; end
    rand_data();
    #1;
    chk("R2 addr", {27'd0, rf_addr}, {27'd0, a});
    chk("R2 ctl", {25'd0, rf_rd_en, rf_wr_en, bus_drv, lat_a_en, lat_b_en, pc_upd},
        {25'd0, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1});
    chk("R7 busy opa", {31'd0, busy}, 32'd1);
    chk("R6 pc before", pc, pc_exp);
    chk("R9 bus opa", bus_data, exp_bus(2'b01, rf_rdata, fu_result));
    // second operand phase
    @(negedge clk);
    if (noisy) begin rs1_idx = $urandom; rs2_idx = $urandom; rd_idx = $urandom; end
    rand_data();
    #1;
    pc_exp = pc_exp + STEP;
    chk("R3 addr", {27'd0, rf_addr}, {27'd0, b});
    chk("R3 ctl", {25'd0, rf_rd_en, rf_wr_en, bus_drv, lat_a_en, lat_b_en, pc_upd},
        {25'd0, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0});
    chk("R6 pc step", pc, pc_exp);
    chk("R9 bus opb", bus_data, exp_bus(2'b01, rf_rdata, fu_result));
    // write-back
    @(negedge clk);
    rand_data();
    #1;
    chk("R4 addr", {27'd0, rf_addr}, {27'd0, d});
    chk("R4 ctl", {25'd0, rf_rd_en, bus_drv, lat_a_en, lat_b_en, pc_upd},
        {25'd0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0});
    chk("R5 wr_en", {31'd0, rf_wr_en}, {31'd0, (d != '0)});
    chk("R7 busy wb", {31'd0, busy}, 32'd1);
    chk("R9 bus wb", bus_data, exp_bus(2'b10, rf_rdata, fu_result));
    // done cycle
    @(negedge clk);
    start = 1'b0;
    rand_data();
    #1;
    chk("R7 done", {30'd0, done, busy}, 32'd2);
    chk("R10 drv off", {30'd0, bus_drv}, 32'd0);
    chk("R6 pc hold", pc, pc_exp);
    chk("R9 bus off", bus_data, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    check_idle_r1();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_idle_r1();

    // directed corners
    run_instr(5'd1, 5'd2, 5'd3, 1'b0);
    run_instr(5'd7, 5'd7, 5'd0, 1'b0);   // rd = 0 suppressed (R5)
    run_instr(5'd31, 5'd0, 5'd31, 1'b1); // busy start ignored, indices held (R8)
    run_instr(5'd0, 5'd31, 5'd0, 1'b1);

    // reset in the middle of an instruction (R1)
    @(negedge clk);
    start = 1'b1; rs1_idx = 5'd9; rs2_idx = 5'd10; rd_idx = 5'd11;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    pc_exp = '0;
    #1;
    check_idle_r1();

    // random mix
    for (int i = 0; i < 400; i++) begin
      run_instr(AW'($urandom), AW'($urandom), ((i % 9) == 0) ? '0 : AW'($urandom),
                bit'($urandom % 2));
    end

    @(negedge clk);
    finish_run();
  end

endmodule